// File: doc/BRIEF.md
# Service Trap Controller

This block runs alongside a small CPU and inspects each fetched 32-bit instruction word. Encodings that ask the CPU to write back to both of its destination operands at once are illegal for the CPU, and this block treats four of them as requests for a service. A service can stop the CPU clock until an external resume, send one console character to a serial transmitter, or stop the clock until input arrives and then store that input in memory. The CPU still executes the instruction as usual. The trap only adds the side action.

The service is chosen from four flag bits: two write-back flags, an input flag and an output flag. Every other bit is ignored. The spare combination, with all four flags set, sends a console character only when tracing is enabled. Each fetch is acted on once at most. The trigger is the rising edge of the instruction-valid strobe, so a stalled clock cannot repeat a service.

Top module: `svc_trap_ctrl`

## Requirements
- R1: After reset, clk_en is 1 and tx_valid and mem_we are 0.
- R2: A service is recognised only when insn[31] and insn[27] are both 1. Bits other than 31, 29, 28 and 27 never affect the choice of service. A word with either of bits 31 or 27 clear leaves clk_en at 1 and produces no transmit and no memory write.
- R3: Halt service (insn & 0xB8000000 == 0x88000000). From the cycle after the fetch, clk_en is 0. It stays 0 until resume is sampled high, and then it returns to 1.
- R4: Console service (masked value 0x98000000). tx_valid rises in the cycle after the fetch, with tx_data equal to cpu_dout[7:0]. tx_valid and tx_data stay unchanged, and clk_en stays 0, until tx_ready is sampled high. Exactly one byte is transferred.
- R5: Spare service (masked value 0xB8000000). With trace_en at 1 it behaves as the console service. With trace_en at 0 it does nothing: clk_en stays 1 and no byte is sent.
- R6: Input-wait service (masked value 0xA8000000). clk_en is 0 from the cycle after the fetch. When rx_valid is sampled, one single-cycle mem_we is issued with mem_addr = insn[7:0] and mem_wdata = rx_data, zero-extended. clk_en is 1 in that same cycle.
- R7: During an input wait, port_in is compared with the value it had at wait entry. A different value that stays unchanged for DEB_TICKS consecutive sample ticks completes the wait with one write of that port value.
- R8: During an input wait, a port change that lasts fewer than DEB_TICKS ticks completes nothing. clk_en stays 0 and no write occurs.
- R9: If a serial byte and a completed port debounce arrive in the same cycle, the serial byte is written and exactly one write occurs.
- R10: Keeping insn_valid high after a service has finished triggers no second service.
- R11: resume outside a halt, and rx_valid outside an input wait, have no effect: clk_en stays 1 and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | High while insn holds a fetched instruction |
| insn | input | 32 | Current instruction word |
| cpu_dout | input | DATA_W | CPU data output bus |
| trace_en | input | 1 | Enables the spare code as console output |
| clk_en | output | 1 | CPU clock enable |
| resume | input | 1 | Releases a halt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| port_in | input | DATA_W | Raw parallel input port |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_addr | output | 8 | Write address, taken from insn[7:0] |
| mem_wdata | output | DATA_W | Write data |

## Verification
The bench builds the block with TICK_DIV = 1 and DEB_TICKS = 4. A sample tick then occurs on every clock, and the debounce window is four cycles long. With these values, a glitch one tick short of the window, a change that completes it, and a serial byte that lands in exactly the cycle the debounce completes can all be placed cycle by cycle. DATA_W keeps its default of 8, so the zero-extension of received bytes is trivial in this build.

// File: rtl/svc_trap_pkg.sv
package svc_trap_pkg;
    localparam int FLAG_WA  = 31;
    localparam int FLAG_IN  = 29;
    localparam int FLAG_OUT = 28;
    localparam int FLAG_WB  = 27;
    localparam logic [31:0] SVC_MASK = (32'd1 << FLAG_WA) | (32'd1 << FLAG_IN)
                                     | (32'd1 << FLAG_OUT) | (32'd1 << FLAG_WB);
    localparam logic [31:0] BASE     = (32'd1 << FLAG_WA) | (32'd1 << FLAG_WB);
    localparam logic [31:0] CODE_HALT  = BASE;
    localparam logic [31:0] CODE_WAIT  = BASE | (32'd1 << FLAG_IN);
    localparam logic [31:0] CODE_OUT   = BASE | (32'd1 << FLAG_OUT);
    localparam logic [31:0] CODE_SPARE = SVC_MASK;

    typedef enum logic [1:0] {SVC_NONE, SVC_HALT, SVC_WAIT, SVC_PUT} svc_e;
    typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_WAIT, ST_TX} st_e;
endpackage

// File: rtl/svc_decode.sv
module svc_decode
    import svc_trap_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        trace_en,
    output svc_e        kind
);
    logic [31:0] masked;

    always_comb begin
        masked = insn & SVC_MASK;
        kind   = SVC_NONE;
        case (masked)
            CODE_HALT:  kind = SVC_HALT;
            CODE_WAIT:  kind = SVC_WAIT;
            CODE_OUT:   kind = SVC_PUT;
            CODE_SPARE: kind = trace_en ? SVC_PUT : SVC_NONE;
            default:    kind = SVC_NONE;
        endcase
    end
endmodule

// File: rtl/svc_debounce.sv
module svc_debounce #(
    parameter int W         = 8,
    parameter int TICK_DIV  = 1000,
    parameter int DEB_TICKS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] port_in,
    output logic         done,
    output logic [W-1:0] value
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEB_TICKS);

    typedef struct packed {
        logic [W-1:0]  ref_v;
        logic [W-1:0]  cand;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t r_q, r_d;
    logic tick;

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = en;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q, div_d;
            always_comb begin
                div_d = '0;
                if (en && div_q != DW'(TICK_DIV - 1)) div_d = div_q + 1'b1;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
            assign tick = en && (div_q == DW'(TICK_DIV - 1));
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (!en) begin
            r_d.ref_v = port_in;
            r_d.cand  = port_in;
            r_d.cnt   = '0;
        end else if (tick) begin
            if (port_in == r_q.ref_v) begin
                r_d.cnt = '0;
            end else if (port_in == r_q.cand && r_q.cnt != '0) begin
                if (r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + 1'b1;
            end else begin
                r_d.cand = port_in;
                r_d.cnt  = CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done  = en && (r_q.cnt == CNT_MAX);
    assign value = r_q.cand;

    p_done_differs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (value != r_q.ref_v));
endmodule

// File: rtl/svc_trap_ctrl.sv
module svc_trap_ctrl
    import svc_trap_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TICK_DIV  = 1000,
    parameter int DEB_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] cpu_dout,
    input  logic              trace_en,
    output logic              clk_en,
    input  logic              resume,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [DATA_W-1:0] port_in,
    output logic              mem_we,
    output logic [7:0]        mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    typedef struct packed {
        st_e               st;
        logic              valid;
        logic              clk_en;
        logic              tx_valid;
        logic [7:0]        tx_data;
        logic              we;
        logic [7:0]        addr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t r_q, r_d;
    svc_e kind;
    logic fire, deb_done;
    logic [DATA_W-1:0] deb_val;

    svc_decode u_dec (
        .insn     (insn),
        .trace_en (trace_en),
        .kind     (kind)
    );

    svc_debounce #(
        .W         (DATA_W),
        .TICK_DIV  (TICK_DIV),
        .DEB_TICKS (DEB_TICKS)
    ) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (r_q.st == ST_WAIT),
        .port_in (port_in),
        .done    (deb_done),
        .value   (deb_val)
    );

    assign fire = insn_valid && !r_q.valid;

    always_comb begin
        r_d       = r_q;
        r_d.valid = insn_valid;
        r_d.we    = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (fire) begin
                    case (kind)
                        SVC_HALT: begin
                            r_d.st     = ST_HALT;
                            r_d.clk_en = 1'b0;
                        end
                        SVC_WAIT: begin
                            r_d.st     = ST_WAIT;
                            r_d.clk_en = 1'b0;
                            r_d.addr   = insn[7:0];
                        end
                        SVC_PUT: begin
                            r_d.st       = ST_TX;
                            r_d.clk_en   = 1'b0;
                            r_d.tx_valid = 1'b1;
                            r_d.tx_data  = cpu_dout[7:0];
                        end
                        default: ;
                    endcase
                end
            end
            ST_HALT: begin
                if (resume) begin
                    r_d.st     = ST_RUN;
                    r_d.clk_en = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    r_d.we     = 1'b1;
                    r_d.wdata  = DATA_W'(rx_data);
                    r_d.st     = ST_RUN;
                    r_d.clk_en = 1'b1;
                end else if (deb_done) begin
                    r_d.we     = 1'b1;
                    r_d.wdata  = deb_val;
                    r_d.st     = ST_RUN;
                    r_d.clk_en = 1'b1;
                end
            end
            ST_TX: begin
                if (tx_ready) begin
                    r_d.tx_valid = 1'b0;
                    r_d.clk_en   = 1'b1;
                    r_d.st       = ST_RUN;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_RUN;
            r_q.clk_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_en    = r_q.clk_en;
    assign tx_valid  = r_q.tx_valid;
    assign tx_data   = r_q.tx_data;
    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && !resume) |=> !clk_en);
    p_tx_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    p_tx_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !clk_en);
    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_we_resumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> clk_en);
    p_no_refire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && insn_valid && $past(insn_valid)) |=> clk_en);
    p_excl_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, mem_we}));
endmodule

// File: tb/sim_svc_trap_ctrl.sv
module sim_svc_trap_ctrl;
    localparam int DW  = 8;
    localparam int DEB = 4;

    logic clk = 0, rst_n = 0;
    logic insn_valid = 0, trace_en = 0, resume = 0, tx_ready = 0, rx_valid = 0;
    logic [31:0] insn = '0;
    logic [DW-1:0] cpu_dout = '0, port_in = '0;
    logic [7:0] rx_data = '0;
    logic clk_en, tx_valid, mem_we;
    logic [7:0] tx_data, mem_addr;
    logic [DW-1:0] mem_wdata;

    always #5 clk = ~clk;

    svc_trap_ctrl #(.DATA_W(DW), .TICK_DIV(1), .DEB_TICKS(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .cpu_dout(cpu_dout), .trace_en(trace_en), .clk_en(clk_en),
        .resume(resume), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .port_in(port_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    typedef struct { logic [15:0] v; string req; } item_t;
    item_t wq[$];
    item_t tq[$];
    int nchk = 0, nerr = 0, wr_seen = 0, tx_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic exp_wr(input logic [7:0] a, input logic [7:0] d, input string req);
        item_t it;
        it.v = {a, d}; it.req = req;
        wq.push_back(it);
    endtask

    task automatic exp_tx(input logic [7:0] d, input string req);
        item_t it;
        it.v = {8'h00, d}; it.req = req;
        tq.push_back(it);
    endtask

    // monitor: compare produced writes and bytes against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_we) begin
            wr_seen++;
            if (wq.size() == 0) chk(0, "R11 unsolicited write", {mem_addr, mem_wdata}, 0);
            else begin
                item_t e;
                e = wq.pop_front();
                chk({mem_addr, mem_wdata} == e.v, e.req, {mem_addr, mem_wdata}, e.v);
            end
        end
        if (rst_n && tx_valid && tx_ready) begin
            tx_seen++;
            if (tq.size() == 0) chk(0, "R5 unsolicited byte", tx_data, 0);
            else begin
                item_t e;
                e = tq.pop_front();
                chk({8'h00, tx_data} == e.v, e.req, tx_data, e.v);
            end
        end
    end

    task automatic fetch(input logic [31:0] w, input bit hold);
        @(negedge clk); insn = w; insn_valid = 1;
        @(negedge clk); if (!hold) insn_valid = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int w0, t0;
        cycles(3);
        rst_n = 1;
        @(negedge clk);
        chk(clk_en && !tx_valid && !mem_we, "R1 reset state", {clk_en, tx_valid, mem_we}, 3'b100);

        // R2: one write-back flag missing
        fetch(32'hB000_0000, 0); cycles(1);
        chk(clk_en, "R2 only WA set", clk_en, 1);
        fetch(32'h3800_0000, 0); cycles(1);
        chk(clk_en, "R2 only WB set", clk_en, 1);

        // R3: halt with noise in other bits
        fetch(32'hC810_FF00, 0);
        chk(!clk_en, "R3 halt entry", clk_en, 0);
        rx_valid = 1; rx_data = 8'hEE; @(negedge clk); rx_valid = 0;
        cycles(4);
        chk(!clk_en, "R3 halt held", clk_en, 0);
        resume = 1; @(negedge clk); resume = 0;
        chk(clk_en, "R3 resumed", clk_en, 1);

        // R11: stray resume and rx_valid while running
        resume = 1; rx_valid = 1; @(negedge clk); resume = 0; rx_valid = 0;
        cycles(2);
        chk(clk_en && wr_seen == 0, "R11 stray inputs", {clk_en, 8'(wr_seen)}, 9'h100);

        // R4: console output with delayed ready
        cpu_dout = 8'h41;
        exp_tx(8'h41, "R4 byte");
        fetch(32'h9800_1200, 0);
        chk(tx_valid && tx_data == 8'h41, "R4 tx presented", {tx_valid, tx_data}, 9'h141);
        chk(!clk_en, "R4 clock stopped", clk_en, 0);
        cpu_dout = 8'h00;
        cycles(3);
        chk(tx_valid && tx_data == 8'h41 && !clk_en, "R4 held until ready", {tx_valid, tx_data}, 9'h141);
        tx_ready = 1; @(negedge clk); tx_ready = 0;
        chk(clk_en && !tx_valid && tx_seen == 1, "R4 complete", {clk_en, tx_valid, 8'(tx_seen)}, 10'h201);

        // R5: spare code with and without trace
        trace_en = 1; cpu_dout = 8'h5A; tx_ready = 1;
        exp_tx(8'h5A, "R5 spare traced");
        fetch(32'hB800_0000, 0); cycles(2);
        chk(tx_seen == 2 && clk_en, "R5 traced sent", tx_seen, 2);
        trace_en = 0;
        fetch(32'hBFFF_FFFF, 0); cycles(3);
        chk(tx_seen == 2 && clk_en, "R5 untraced ignored", tx_seen, 2);
        tx_ready = 0;

        // R6: input wait finished by serial byte
        w0 = wr_seen;
        exp_wr(8'h33, 8'h77, "R6 serial write");
        fetch(32'hE800_0033, 0);
        chk(!clk_en, "R6 clock stopped", clk_en, 0);
        cycles(3);
        rx_valid = 1; rx_data = 8'h77; @(negedge clk); rx_valid = 0;
        chk(clk_en, "R6 clock back", clk_en, 1);
        cycles(1);
        chk(wr_seen == w0 + 1, "R6 one write", wr_seen - w0, 1);

        // R7: debounced port change
        port_in = 8'h10;
        w0 = wr_seen;
        exp_wr(8'h44, 8'h99, "R7 port write");
        fetch(32'hE800_0044, 0);
        port_in = 8'h99;
        cycles(DEB + 4);
        chk(wr_seen == w0 + 1 && clk_en, "R7 debounced completion", wr_seen - w0, 1);

        // R8: glitch one tick short, then serial completes
        w0 = wr_seen;
        fetch(32'hE800_0055, 0);
        port_in = 8'h01; cycles(DEB - 1);
        port_in = 8'h99; cycles(8);
        chk(wr_seen == w0 && !clk_en, "R8 glitch ignored", wr_seen - w0, 0);
        exp_wr(8'h55, 8'h66, "R8 serial after glitch");
        rx_valid = 1; rx_data = 8'h66; @(negedge clk); rx_valid = 0;
        cycles(1);
        chk(wr_seen == w0 + 1, "R8 completed once", wr_seen - w0, 1);

        // R9: serial byte in the very cycle the debounce completes
        w0 = wr_seen;
        exp_wr(8'h21, 8'hC3, "R9 serial wins");
        fetch(32'hE800_0021, 0);
        port_in = 8'h5C;
        cycles(DEB);
        rx_valid = 1; rx_data = 8'hC3; @(negedge clk); rx_valid = 0;
        cycles(4);
        chk(wr_seen == w0 + 1 && clk_en, "R9 single write", wr_seen - w0, 1);

        // R10: instruction valid held high
        t0 = tx_seen; tx_ready = 1; cpu_dout = 8'h7E;
        exp_tx(8'h7E, "R10 first byte");
        fetch(32'hD800_7E00, 1);
        cycles(10);
        chk(tx_seen == t0 + 1 && clk_en, "R10 no refire", tx_seen - t0, 1);
        insn_valid = 0; tx_ready = 0;

        cycles(2);
        chk(wq.size() == 0 && tq.size() == 0, "R6 scoreboard drained", wq.size() + tq.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule